// File: doc/BRIEF.md
# Tagged-Table Operand Fetch Unit

This unit carries out the operand-fetch step of a stack machine. In that machine, every memory reference passes through a per-program table of tagged 48-bit words. A 12-bit syllable arrives with a start strobe, together with the base address of the running program's table. For an operand call, the unit reads the selected table entry and acts according to the entry's tag:

- A scalar entry is pushed onto the stack.
- A program descriptor raises a call request and fetches nothing more.
- A data descriptor whose segment is absent raises a missing-segment trap.
- A data descriptor whose index is out of range raises a bounds error.
- Any other data descriptor gives an indexed element read. The index comes from the B register, and the fetched word replaces it.

The unit also accepts literal syllables, which push a 10-bit value, and drop syllables, which pop one element. This lets a sequencer build up the stack state that operand calls then use.

The two top stack elements are held in registers A (the top) and B. Deeper elements are spilled to a small circular stack RAM. Memory is reached through a synchronous read port with one cycle of latency. A one-cycle `done` pulse closes each syllable, and any result flags are valid only during that pulse.

The controller has six states:

- IDLE accepts a syllable.
- TBL_RD issues the table read.
- TBL_WT classifies the returned entry.
- ELM_RD issues the element read.
- ELM_WT loads the element into B.
- DONE pulses completion.

The transitions are:

- IDLE to DONE for a literal, drop or reserved syllable.
- IDLE to TBL_RD for an operand call.
- TBL_RD to TBL_WT.
- TBL_WT to DONE for a scalar, call, trap or bounds error.
- TBL_WT to ELM_RD for an in-range present data descriptor.
- ELM_RD to ELM_WT.
- ELM_WT to DONE.
- DONE to IDLE.

Top module: `ofu_operand_fetch`

## Requirements
- R1: After reset, A and B are zero, and busy, done, mem_rd_en, call_req, bounds_err and absent_trap are all low.
- R2: A syllable with bits 11:10 = 00 is a literal. Its bits 9:0, zero-extended to 48 bits, go into A, the old A goes into B, and the old B is spilled. done rises one cycle after the start edge.
- R3: A syllable with bits 11:10 = 10 is a drop. The old B goes into A, and B is refilled with the most recently spilled word, so deeper elements come back in last-in, first-out order. done rises one cycle after the start edge.
- R4: A syllable with bits 11:10 = 11 is ignored. A and B are unchanged, no flag is raised and memory is not read, and done rises one cycle after the start edge.
- R5: A syllable with bits 11:10 = 01 is an operand call. It reads the table word at the address table_base plus bits 9:0 (15-bit wrap), across the full index range 0 to 1023. Memory reads are never issued in two consecutive cycles.
- R6: A table word with bit 47 = 0 is a scalar. It is pushed like a literal, and done rises three cycles after the start edge, after exactly one memory read.
- R7: A table word with bits 47 and 46 both set is a program descriptor. During done, call_req is high and call_target equals bits 14:0 of the word. A and B are unchanged, and only the table read is made.
- R8: A table word with bit 47 = 1, bit 46 = 0 and bit 45 = 0 is an absent data segment. It raises absent_trap during done, leaves A and B unchanged and makes no element read. This check takes precedence over the bounds check.
- R9: For a present data descriptor, if B is greater than or equal to the size in bits 44:35, bounds_err is raised during done. A and B are unchanged, and no element read is made.
- R10: For a present data descriptor with B below the size, the word at bits 14:0 plus B is read into B. A is unchanged, two memory reads are made, and done rises five cycles after the start edge.
- R11: busy is high from the cycle after an operand call is accepted until the DONE state. A start strobe is ignored while busy is high, and done is a single-cycle pulse.
- R12: call_req, bounds_err and absent_trap are low whenever done is low, and at most one of them is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Accept the syllable in IDLE |
| syllable | input | 12 | Bits 11:10 opcode, bits 9:0 literal or table index |
| table_base | input | 15 | Base address of the program's table |
| busy | output | 1 | Operand call in progress |
| done | output | 1 | One-cycle completion pulse |
| call_req | output | 1 | Program descriptor found |
| call_target | output | 15 | Code address from the program descriptor |
| bounds_err | output | 1 | Index out of range |
| absent_trap | output | 1 | Referenced segment not present |
| stack_a | output | 48 | Top-of-stack register A |
| stack_b | output | 48 | Second stack register B |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | 15 | Memory read address |
| mem_rdata | input | 48 | Read data, valid the cycle after mem_rd_en |

## Verification
A corrupted stack pointer or a spill slot written in the wrong place stays hidden until a drop brings that slot back into B. The bench therefore pushes well past the two registers and then pops back to the oldest elements. A misclassified entry or a wrongly latched segment address shows up in the very syllable concerned: the flag, B, the done latency or the number of memory reads is wrong when done pulses. A state that fails to clear shows up as done or a flag still high one cycle later.

// File: rtl/ofu_pkg.sv
package ofu_pkg;
    localparam int WORD_W   = 48;
    localparam int SYL_W    = 12;
    localparam int IDX_W    = 10;
    localparam int LIT_W    = 10;
    localparam int MADDR_W  = 15;
    localparam int OP_W     = SYL_W - IDX_W;

    // Table word field positions (behaviour depends on these)
    localparam int F_DESC    = 47;
    localparam int F_PROG    = 46;
    localparam int F_PRES    = 45;
    localparam int F_SIZE_LO = 35;
    localparam int F_SIZE_W  = 10;

    typedef enum logic [OP_W-1:0] {
        OP_LIT  = 2'b00,
        OP_OPND = 2'b01,
        OP_DROP = 2'b10,
        OP_RSVD = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_TBL_RD,
        S_TBL_WT,
        S_ELM_RD,
        S_ELM_WT,
        S_DONE
    } state_e;

    typedef enum logic [1:0] {
        END_NONE,
        END_CALL,
        END_BOUNDS,
        END_ABSENT
    } end_e;
endpackage

// File: rtl/ofu_entry_decode.sv
module ofu_entry_decode
    import ofu_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int AW = MADDR_W
) (
    input  logic [W-1:0]  entry_i,
    input  logic [W-1:0]  index_i,
    output logic          is_desc_o,
    output logic          is_prog_o,
    output logic          present_o,
    output logic          in_bounds_o,
    output logic [AW-1:0] seg_addr_o,
    output logic [AW-1:0] elem_addr_o
);
    logic [F_SIZE_W-1:0] seg_size;
    logic                unused_mid;

    assign unused_mid = ^entry_i[F_SIZE_LO-1:AW];

    always_comb begin
        is_desc_o   = entry_i[F_DESC];
        is_prog_o   = entry_i[F_PROG];
        present_o   = entry_i[F_PRES];
        seg_size    = entry_i[F_SIZE_LO +: F_SIZE_W];
        // full-width compare: any high index bit is out of range
        in_bounds_o = index_i < W'(seg_size);
        seg_addr_o  = entry_i[AW-1:0];
        elem_addr_o = entry_i[AW-1:0] + index_i[AW-1:0];
    end
endmodule

// File: rtl/ofu_stack.sv
module ofu_stack #(
    parameter int W     = 48,
    parameter int DEPTH = 8          // power of two: pointer wraps naturally
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] push_val_i,
    input  logic         pop_i,
    input  logic         load_b_i,
    input  logic [W-1:0] load_b_val_i,
    output logic [W-1:0] a_o,
    output logic [W-1:0] b_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  a_q;
    logic [W-1:0]  b_q;
    logic [W-1:0]  spill_q [DEPTH];
    logic [PW-1:0] sp_q;
    logic [PW-1:0] sp_dn;

    assign sp_dn = sp_q - 1'b1;
    assign a_o   = a_q;
    assign b_o   = b_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q  <= '0;
            b_q  <= '0;
            sp_q <= '0;
            for (int i = 0; i < DEPTH; i++) spill_q[i] <= '0;
        end else if (push_i) begin
            spill_q[sp_q] <= b_q;
            sp_q          <= sp_q + 1'b1;
            b_q           <= a_q;
            a_q           <= push_val_i;
        end else if (pop_i) begin
            a_q  <= b_q;
            b_q  <= spill_q[sp_dn];
            sp_q <= sp_dn;
        end else if (load_b_i) begin
            b_q <= load_b_val_i;
        end
    end

    // R3: the controller never requests two stack moves in one cycle
    assert_one_stack_op_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({push_i, pop_i, load_b_i}) <= 1);
endmodule

// File: rtl/ofu_operand_fetch.sv
module ofu_operand_fetch
    import ofu_pkg::*;
#(
    parameter int STACK_DEPTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [SYL_W-1:0]   syllable,
    input  logic [MADDR_W-1:0] table_base,
    output logic               busy,
    output logic               done,
    output logic               call_req,
    output logic [MADDR_W-1:0] call_target,
    output logic               bounds_err,
    output logic               absent_trap,
    output logic [WORD_W-1:0]  stack_a,
    output logic [WORD_W-1:0]  stack_b,
    output logic               mem_rd_en,
    output logic [MADDR_W-1:0] mem_addr,
    input  logic [WORD_W-1:0]  mem_rdata
);
    state_e state_q, state_d;
    end_e   end_q, end_d;
    op_e    op_in;

    logic [MADDR_W-1:0] tbl_addr_q;
    logic [MADDR_W-1:0] elem_addr_q;
    logic [MADDR_W-1:0] tgt_q;

    logic               st_push, st_pop, st_load;
    logic [WORD_W-1:0]  st_push_val, st_load_val;

    logic               dec_desc, dec_prog, dec_pres, dec_inb;
    logic [MADDR_W-1:0] dec_seg, dec_elem;

    assign op_in = op_e'(syllable[SYL_W-1 -: OP_W]);

    ofu_entry_decode #(.W(WORD_W), .AW(MADDR_W)) u_decode (
        .entry_i    (mem_rdata),
        .index_i    (stack_b),
        .is_desc_o  (dec_desc),
        .is_prog_o  (dec_prog),
        .present_o  (dec_pres),
        .in_bounds_o(dec_inb),
        .seg_addr_o (dec_seg),
        .elem_addr_o(dec_elem)
    );

    ofu_stack #(.W(WORD_W), .DEPTH(STACK_DEPTH)) u_stack (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (st_push),
        .push_val_i  (st_push_val),
        .pop_i       (st_pop),
        .load_b_i    (st_load),
        .load_b_val_i(st_load_val),
        .a_o         (stack_a),
        .b_o         (stack_b)
    );

    // Next-state and end-cause selection
    always_comb begin
        state_d = state_q;
        end_d   = END_NONE;
        unique case (state_q)
            S_IDLE: begin
                if (start) state_d = (op_in == OP_OPND) ? S_TBL_RD : S_DONE;
            end
            S_TBL_RD: state_d = S_TBL_WT;
            S_TBL_WT: begin
                state_d = S_DONE;
                if (dec_desc) begin
                    if (dec_prog)      end_d = END_CALL;
                    else if (!dec_pres) end_d = END_ABSENT;
                    else if (!dec_inb)  end_d = END_BOUNDS;
                    else                state_d = S_ELM_RD;
                end
            end
            S_ELM_RD: state_d = S_ELM_WT;
            S_ELM_WT: state_d = S_DONE;
            S_DONE:   state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Per-syllable context registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            end_q       <= END_NONE;
            tbl_addr_q  <= '0;
            elem_addr_q <= '0;
            tgt_q       <= '0;
        end else begin
            if (state_q == S_IDLE && start)
                tbl_addr_q <= table_base + MADDR_W'(syllable[IDX_W-1:0]);
            if (state_q == S_TBL_WT) begin
                end_q       <= end_d;
                tgt_q       <= dec_seg;
                elem_addr_q <= dec_elem;
            end else if (state_q == S_DONE) begin
                end_q <= END_NONE;
            end
        end
    end

    // Outputs and stack controls
    always_comb begin
        busy        = 1'b0;
        done        = 1'b0;
        mem_rd_en   = 1'b0;
        mem_addr    = '0;
        st_push     = 1'b0;
        st_push_val = '0;
        st_pop      = 1'b0;
        st_load     = 1'b0;
        st_load_val = '0;
        call_req    = 1'b0;
        bounds_err  = 1'b0;
        absent_trap = 1'b0;
        call_target = tgt_q;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    case (op_in)
                        OP_LIT: begin
                            st_push     = 1'b1;
                            st_push_val = WORD_W'(syllable[LIT_W-1:0]);
                        end
                        OP_DROP: st_pop = 1'b1;
                        default: ;
                    endcase
                end
            end
            S_TBL_RD: begin
                busy      = 1'b1;
                mem_rd_en = 1'b1;
                mem_addr  = tbl_addr_q;
            end
            S_TBL_WT: begin
                busy = 1'b1;
                if (!dec_desc) begin
                    st_push     = 1'b1;
                    st_push_val = mem_rdata;
                end
            end
            S_ELM_RD: begin
                busy      = 1'b1;
                mem_rd_en = 1'b1;
                mem_addr  = elem_addr_q;
            end
            S_ELM_WT: begin
                busy        = 1'b1;
                st_load     = 1'b1;
                st_load_val = mem_rdata;
            end
            S_DONE: begin
                done        = 1'b1;
                call_req    = (end_q == END_CALL);
                bounds_err  = (end_q == END_BOUNDS);
                absent_trap = (end_q == END_ABSENT);
            end
            default: ;
        endcase
    end

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_single_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);

    assert_one_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({call_req, bounds_err, absent_trap}));

    assert_desc_no_push_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_TBL_WT && dec_desc) |=> ($stable(stack_a) && $stable(stack_b)));

    assert_no_busy_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
endmodule

// File: tb/tb_ofu_operand_fetch.sv
module tb_ofu_operand_fetch;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 23;

    localparam logic [47:0] SCL_S  = 48'h0000_1234_5678;
    localparam logic [47:0] SCL_T  = 48'h7654_3210_0FED;
    localparam logic [47:0] D_PROG = 48'hC000_0000_0ABC;
    localparam logic [47:0] D_DATA = 48'hA020_0000_0200; // present, size 4, at 0x200
    localparam logic [47:0] D_ABS  = 48'h8020_0000_0200; // absent
    localparam logic [47:0] EL0    = 48'h0BAD_0000_0000;
    localparam logic [47:0] EL3    = 48'h0BAD_0000_0003;

    typedef struct packed {
        logic [11:0] syl;
        logic [47:0] a;
        logic [47:0] b;
        logic [2:0]  flags;   // {call, bounds, absent}
        logic [14:0] tgt;
        logic [3:0]  lat;
        logic [1:0]  reads;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{12'h005, 48'h5,   48'h0,   3'b000, 15'h0,     4'd1, 2'd0},
        '{12'h3FF, 48'h3FF, 48'h5,   3'b000, 15'h0,     4'd1, 2'd0},
        '{12'h002, 48'h2,   48'h3FF, 3'b000, 15'h0,     4'd1, 2'd0},
        '{12'h800, 48'h3FF, 48'h5,   3'b000, 15'h0,     4'd1, 2'd0},
        '{12'h800, 48'h5,   48'h0,   3'b000, 15'h0,     4'd1, 2'd0},
        '{12'h400, SCL_S,   48'h5,   3'b000, 15'h0,     4'd3, 2'd1},
        '{12'h003, 48'h3,   SCL_S,   3'b000, 15'h0,     4'd1, 2'd0},
        '{12'h007, 48'h7,   48'h3,   3'b000, 15'h0,     4'd1, 2'd0},
        '{12'h402, 48'h7,   EL3,     3'b000, 15'h0,     4'd5, 2'd2},
        '{12'h401, 48'h7,   EL3,     3'b100, 15'h0ABC,  4'd3, 2'd1},
        '{12'hC00, 48'h7,   EL3,     3'b000, 15'h0,     4'd1, 2'd0},
        '{12'h004, 48'h4,   48'h7,   3'b000, 15'h0,     4'd1, 2'd0},
        '{12'h009, 48'h9,   48'h4,   3'b000, 15'h0,     4'd1, 2'd0},
        '{12'h402, 48'h9,   48'h4,   3'b010, 15'h0,     4'd3, 2'd1},
        '{12'h403, 48'h9,   48'h4,   3'b001, 15'h0,     4'd3, 2'd1},
        '{12'h800, 48'h4,   48'h7,   3'b000, 15'h0,     4'd1, 2'd0},
        '{12'h800, 48'h7,   EL3,     3'b000, 15'h0,     4'd1, 2'd0},
        '{12'h800, EL3,     SCL_S,   3'b000, 15'h0,     4'd1, 2'd0},
        '{12'h800, SCL_S,   48'h5,   3'b000, 15'h0,     4'd1, 2'd0},
        '{12'h000, 48'h0,   SCL_S,   3'b000, 15'h0,     4'd1, 2'd0},
        '{12'h001, 48'h1,   48'h0,   3'b000, 15'h0,     4'd1, 2'd0},
        '{12'h402, 48'h1,   EL0,     3'b000, 15'h0,     4'd5, 2'd2},
        '{12'h7FF, SCL_T,   48'h1,   3'b000, 15'h0,     4'd3, 2'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [11:0] syllable = '0;
    logic [14:0] table_base = 15'h0100;
    logic        busy, done, call_req, bounds_err, absent_trap, mem_rd_en;
    logic [14:0] call_target, mem_addr;
    logic [47:0] stack_a, stack_b;
    logic [47:0] mem_rdata = '0;
    logic [47:0] mem [2048];
    int          rd_count = 0;
    int          checks = 0;
    int          errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ofu_operand_fetch dut (
        .clk(clk), .rst_n(rst_n), .start(start), .syllable(syllable),
        .table_base(table_base), .busy(busy), .done(done),
        .call_req(call_req), .call_target(call_target),
        .bounds_err(bounds_err), .absent_trap(absent_trap),
        .stack_a(stack_a), .stack_b(stack_b),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rdata <= mem[mem_addr[10:0]];
            rd_count  <= rd_count + 1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [47:0] act,
                         input logic [47:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic string tag_of(input vec_t v);
        case (v.syl[11:10])
            2'b00: return "R2";
            2'b10: return "R3";
            2'b11: return "R4";
            default: begin
                if (v.syl[9:0] == 10'h3FF) return "R5";
                if (v.flags[2]) return "R7";
                if (v.flags[0]) return "R8";
                if (v.flags[1]) return "R9";
                if (v.reads == 2'd2) return "R10";
                return "R6";
            end
        endcase
    endfunction

    task automatic run_vec(input vec_t v);
        int    lat;
        int    r0;
        string t;
        t = tag_of(v);
        @(negedge clk);
        syllable = v.syl;
        start    = 1'b1;
        r0       = rd_count;
        @(posedge clk);
        lat = 1;
        @(negedge clk);
        start = 1'b0;
        while (!done && lat < 20) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
        check(lat == int'(v.lat), {t, " latency"}, 48'(lat), 48'(v.lat));
        check(stack_a == v.a, {t, " A"}, stack_a, v.a);
        check(stack_b == v.b, {t, " B"}, stack_b, v.b);
        check({call_req, bounds_err, absent_trap} == v.flags, {t, " flags"},
              48'({call_req, bounds_err, absent_trap}), 48'(v.flags));
        if (v.flags[2])
            check(call_target == v.tgt, "R7 call_target", 48'(call_target), 48'(v.tgt));
        check(rd_count - r0 == int'(v.reads), {t, " reads"}, 48'(rd_count - r0), 48'(v.reads));
        @(negedge clk);
        check(!done && !call_req && !bounds_err && !absent_trap, "R12 flags clear after done",
              48'({done, call_req, bounds_err, absent_trap}), 48'h0);
    endtask

    initial begin
        for (int i = 0; i < 2048; i++) mem[i] = 48'h0;
        mem[256]  = SCL_S;
        mem[257]  = D_PROG;
        mem[258]  = D_DATA;
        mem[259]  = D_ABS;
        mem[1279] = SCL_T;
        for (int i = 0; i < 4; i++) mem[512 + i] = EL0 + 48'(i);
        mem[516]  = 48'h0FFF_FFFF_FFFF;

        repeat (3) @(negedge clk);
        // R1 reset state
        check(stack_a == 48'h0 && stack_b == 48'h0, "R1 stack zero", stack_a | stack_b, 48'h0);
        check(!busy && !done && !mem_rd_en && !call_req && !bounds_err && !absent_trap,
              "R1 controls low",
              48'({busy, done, mem_rd_en, call_req, bounds_err, absent_trap}), 48'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done, "R1 idle after release", 48'({busy, done}), 48'h0);

        for (int k = 0; k < NV; k++) run_vec(VECS[k]);

        // R11: start held during busy is ignored; busy high while fetching
        @(negedge clk);
        syllable = 12'h400;
        start    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        syllable = 12'h005;
        check(busy == 1'b1, "R11 busy during fetch", 48'(busy), 48'h1);
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1 && !done, "R11 still busy", 48'({busy, done}), 48'h2);
        @(posedge clk);
        @(negedge clk);
        check(done == 1'b1 && !busy, "R11 done after 3 cycles", 48'({busy, done}), 48'h1);
        check(stack_a == SCL_S && stack_b == SCL_T, "R11 extra start ignored",
              stack_a, SCL_S);
        @(negedge clk);
        check(!done && stack_a == SCL_S, "R11 single pulse, no late literal",
              stack_a, SCL_S);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual hung expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule